// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block takes a signed word as a serial stream, one bit per clock, least significant bit first, and returns its additive inverse as a serial stream in the same order. Each result bit depends only on the current input bit and one bit of state. That state records whether a set bit has already passed in the current word. No inverted copy of the word is built and no carry chain is needed, so any word length works without change.

A word is framed by a start strobe on its first bit and an end strobe on its last bit. Both count only on cycles where the input qualifier is high. Every output is registered, so each result bit appears exactly one clock after the bit that produced it. On the output cycle that carries the last bit, two per-word flags report whether the word was all zeros and whether it was the one value that cannot be negated: the sign bit set and every lower bit clear.

Top module: `serial_negator`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released with no input, every output is 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. `out_eow` equals `in_valid && in_eow` delayed by one clock.
- R3: Each zero bit of a word that comes before the word's first set bit is copied to the output unchanged.
- R4: The first set bit of a word, counting from the LSB, is copied to the output unchanged.
- R5: Every bit of a word that follows its first set bit is output inverted. The output word is therefore (2^N − x) mod 2^N.
- R6: A valid bit with `in_sow` high begins a new word. That bit is handled as though no set bit has been seen, even if an earlier word was never ended.
- R7: A cycle with `in_valid` low consumes nothing and leaves the word state unchanged. On the following clock `out_valid`, `out_bit`, `out_eow` and both flags are 0.
- R8: An all-zero word produces an all-zero output word. `out_zero` is 1 on its end-of-word output cycle.
- R9: The most negative word (sign bit 1, lower bits 0) produces itself. `out_ovf` is 1 on its end-of-word output cycle.
- R10: `out_ovf` and `out_zero` are 0 on every output cycle other than an end-of-word cycle, and they are never both 1.
- R11: A one-bit word (start and end strobes on the same valid cycle) is handled correctly: input 1 gives output 1 with `out_ovf`, and input 0 gives output 0 with `out_zero`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit qualifier |
| in_sow | input | 1 | First bit of a word (used only when in_valid) |
| in_eow | input | 1 | Last bit of a word (used only when in_valid) |
| in_bit | input | 1 | Serial data bit, LSB first |
| out_valid | output | 1 | Output bit qualifier, one clock after input |
| out_bit | output | 1 | Negated serial bit |
| out_eow | output | 1 | Output bit is the last of its word |
| out_ovf | output | 1 | Word was the most negative value; valid with out_eow |
| out_zero | output | 1 | Word was zero; valid with out_eow |

## Verification
The only state is the one-bit "set bit seen" register. If it is wrong, the error shows at the ports within one clock: the next valid output bit is inverted when it should be copied, or copied when it should be inverted. A stale flag carried across a start strobe corrupts the first bit of the next word. A flag that drops in the middle of a word re-copies a later bit. Every 8-bit value is streamed with and without idle gaps and compared with an arithmetic negation. Aborted words and one-bit words are also run, so each of these faults changes at least one observed bit or per-word flag.

// File: rtl/serial_negator_pkg.sv
package serial_negator_pkg;

  // Output bit for one serial step: copy until a set bit has passed, invert after.
  function automatic logic neg_step_bit(input logic seen, input logic din);
    return din ^ seen;
  endfunction

  // Seen-state after consuming one bit.
  function automatic logic neg_step_seen(input logic seen, input logic din);
    return seen | din;
  endfunction

  // Per-word classification, evaluated on the last bit.
  typedef struct packed {
    logic ovf;
    logic zero;
  } word_flags_t;

  function automatic word_flags_t neg_classify(input logic seen, input logic last_bit);
    word_flags_t f;
    f.ovf  = ~seen & last_bit;
    f.zero = ~seen & ~last_bit;
    return f;
  endfunction

endpackage

// File: rtl/serial_negator_track.sv
module serial_negator_track
  import serial_negator_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sow,
  input  logic in_eow,
  input  logic in_bit,
  output logic eff_seen,
  output logic step_bit,
  output word_flags_t step_flags
);

  logic seen_q;
  logic seen_d;

  // State as seen by the current bit: a start strobe forces the cleared state.
  assign eff_seen   = (in_valid && in_sow) ? 1'b0 : seen_q;
  assign step_bit   = neg_step_bit(eff_seen, in_bit);
  assign step_flags = neg_classify(eff_seen, in_bit);

  always_comb begin
    seen_d = seen_q;
    if (in_valid) begin
      if (in_eow) seen_d = 1'b0;
      else        seen_d = neg_step_seen(eff_seen, in_bit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  // Once set inside a word, the state stays set until a word boundary.
  assert_seen_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_seen && !in_eow) |=> (seen_q));

  // Idle cycles leave the state untouched.
  assert_idle_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> $stable(seen_q));

endmodule

// File: rtl/serial_negator_out.sv
module serial_negator_out
  import serial_negator_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_eow,
  input  logic step_bit,
  input  word_flags_t step_flags,
  output logic out_valid,
  output logic out_bit,
  output logic out_eow,
  output logic out_ovf,
  output logic out_zero
);

  logic last_step;
  assign last_step = in_valid && in_eow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_eow   <= 1'b0;
      out_ovf   <= 1'b0;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_bit   <= in_valid ? step_bit : 1'b0;
      out_eow   <= last_step;
      out_ovf   <= last_step ? step_flags.ovf  : 1'b0;
      out_zero  <= last_step ? step_flags.zero : 1'b0;
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n)) |-> (out_valid == $past(in_valid)));

  assert_flags_on_eow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ovf || out_zero) |-> (out_eow && out_valid));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_ovf && out_zero));

  assert_ovf_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> out_bit);

  assert_zero_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_zero |-> !out_bit);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_bit && !out_eow));

endmodule

// File: rtl/serial_negator.sv
module serial_negator
  import serial_negator_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sow,
  input  logic in_eow,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit,
  output logic out_eow,
  output logic out_ovf,
  output logic out_zero
);

  logic        eff_seen;
  logic        step_bit;
  word_flags_t step_flags;

  serial_negator_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sow     (in_sow),
    .in_eow     (in_eow),
    .in_bit     (in_bit),
    .eff_seen   (eff_seen),
    .step_bit   (step_bit),
    .step_flags (step_flags)
  );

  serial_negator_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_eow     (in_eow),
    .step_bit   (step_bit),
    .step_flags (step_flags),
    .out_valid  (out_valid),
    .out_bit    (out_bit),
    .out_eow    (out_eow),
    .out_ovf    (out_ovf),
    .out_zero   (out_zero)
  );

  // A start strobe always presents the cleared state to its bit.
  assert_sow_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sow) |-> !eff_seen);

  // Before any set bit, the output bit equals the input bit.
  assert_copy_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !eff_seen) |=> (out_bit == $past(in_bit)));

endmodule

// File: tb/serial_negator_bench.sv
module serial_negator_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_sow = 1'b0;
  logic in_eow = 1'b0;
  logic in_bit = 1'b0;
  logic out_valid, out_bit, out_eow, out_ovf, out_zero;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_negator u_serial_negator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sow(in_sow),
    .in_eow(in_eow), .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit),
    .out_eow(out_eow), .out_ovf(out_ovf), .out_zero(out_zero)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then sample the registered outputs after the edge.
  task automatic step(input logic v, input logic s, input logic e, input logic b);
    @(negedge clk);
    in_valid = v; in_sow = s; in_eow = e; in_bit = b;
    @(posedge clk);
    #1;
  endtask

  // Stream one word of 'width' bits, LSB first, and check against arithmetic negation.
  task automatic run_word(input int val, input int width, input bit gaps);
    int   mask;
    int   got;
    int   expv;
    bit   ovf_exp, zero_exp;
    bit   ovf_got, zero_got, eow_got, flag_early;
    bit   gap_ok;
    got = 0; flag_early = 0; gap_ok = 1;
    ovf_got = 0; zero_got = 0; eow_got = 0;
    mask = (1 << width) - 1;
    expv = (0 - val) & mask;
    ovf_exp  = (val == (1 << (width - 1)));
    zero_exp = (val == 0);
    for (int i = 0; i < width; i++) begin
      step(1'b1, i == 0, i == width - 1, val[i]);
      if (out_valid) got |= (int'(out_bit) << i);
      if (i == width - 1) begin
        ovf_got = out_ovf; zero_got = out_zero; eow_got = out_eow;
      end else if (out_ovf || out_zero || out_eow) begin
        flag_early = 1;
      end
      if (gaps && i != width - 1) begin
        step(1'b0, 1'b1, 1'b1, 1'b1);
        if (out_valid || out_bit || out_eow || out_ovf || out_zero) gap_ok = 0;
      end
    end
    if (zero_exp)     check(got == expv, "R8 zero word value", got, expv);
    else if (ovf_exp) check(got == expv, "R9 most negative value", got, expv);
    else              check(got == expv, "R3 R4 R5 negated value", got, expv);
    check(ovf_got == ovf_exp, "R9 overflow flag", ovf_got, ovf_exp);
    check(zero_got == zero_exp, "R8 zero flag", zero_got, zero_exp);
    check(eow_got && !flag_early, "R10 flags only on end of word", flag_early, 0);
    if (gaps) check(gap_ok, "R7 idle cycles quiet and ignored", gap_ok, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(1'b1, 1'b1, 1'b1, 1'b1);
    check({out_valid, out_bit, out_eow, out_ovf, out_zero} == 5'b0, "R1 outputs in reset",
          {out_valid, out_bit, out_eow, out_ovf, out_zero}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check({out_valid, out_bit, out_eow, out_ovf, out_zero} == 5'b0, "R1 outputs after reset",
          {out_valid, out_bit, out_eow, out_ovf, out_zero}, 0);

    // R2: valid and eow delays
    step(1'b1, 1'b1, 1'b0, 1'b0);
    check(out_valid == 1'b1 && out_eow == 1'b0, "R2 valid follows one clock later", out_valid, 1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(out_valid == 1'b0, "R2 valid drops one clock later", out_valid, 0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    check(out_eow == 1'b1, "R2 eow follows one clock later", out_eow, 1);

    // Exhaustive 8-bit sweep, back to back
    for (int v = 0; v < 256; v++) run_word(v, 8, 1'b0);
    // Exhaustive 8-bit sweep with idle gaps between bits
    for (int v = 0; v < 256; v++) run_word(v, 8, 1'b1);

    // R6: abandoned word with a set bit, then a new word 3 -> 253
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    begin
      int got;
      got = 0;
      for (int i = 0; i < 8; i++) begin
        step(1'b1, i == 0, i == 7, (8'd3 >> i) & 1'b1);
        got |= (int'(out_bit) << i);
      end
      check(got == 253, "R6 start strobe clears state", got, 253);
    end

    // R11: one-bit words
    step(1'b1, 1'b1, 1'b1, 1'b1);
    check(out_bit && out_ovf && !out_zero, "R11 one-bit word of 1",
          {out_bit, out_ovf, out_zero}, 3'b110);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    check(!out_bit && !out_ovf && out_zero, "R11 one-bit word of 0",
          {out_bit, out_ovf, out_zero}, 3'b001);

    // Width 4 corner words
    run_word(8, 4, 1'b0);
    run_word(7, 4, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule